// File: doc/BRIEF.md
# Preemptive DMA Channel Scheduler

This block decides which of eight DMA channels moves data and in which order. Each channel carries a pending-request flag and a suspended flag. The block issues one data unit at a time on a simple transfer interface. The scheduler presents a source address, a destination address and a channel number. It then waits for a completion strobe before it advances the addresses and reduces the remaining count. Channel 0 has the highest priority and channel 7 the lowest.

A request from a more urgent channel never cuts a data unit short. When the unit in flight completes, the running channel stores its remaining count and both addresses in a per-channel context slot. It then marks itself suspended and steps aside. Once the more urgent work is done, every channel that is suspended or requesting competes again, and the lowest number wins. A suspended channel continues from its stored context and ignores its start values. Suspensions can stack several levels deep. A 32-bit read-only status word reports which channels are suspended.

Top module: `dma_preempt_sched`

## Requirements
- R1: After reset the status word reads 0 and `xfer_valid` is low.
- R2: A fresh channel starts from its `cfg_src`, `cfg_dst` and `cfg_cnt` slices. Slice k occupies bits [k*W +: W]. Each accepted unit (`xfer_valid` and `xfer_done` high at a clock edge) adds 1 to both addresses and subtracts 1 from the count. When the count reaches zero the request is dropped and the block goes idle.
- R3: When several channels are pending at arbitration time, only the lowest-numbered one is granted.
- R4: While a unit is outstanding (`xfer_done` low), `xfer_valid`, `xfer_ch`, `xfer_src` and `xfer_dst` hold their values, whatever requests arrive.
- R5: If a lower-numbered channel is pending when a unit completes, and that unit is not the last, the active channel suspends. Bit k of the status word (k being that channel) becomes 1 and `xfer_valid` is low for one cycle. A suspended channel always remains pending.
- R6: The channel that caused the suspension is the next one issued.
- R7: A suspended channel resumes from its stored count and addresses. New start values or a repeated request do not change this. Its status bit clears in the cycle it resumes.
- R8: After the preempting channel finishes, suspended and requesting channels are served in ascending channel order.
- R9: Suspension nests. A channel that preempted another can itself be suspended, and several status bits can be 1 at once.
- R10: A request for the channel already active does not suspend it and does not start a second run.
- R11: Bits 31:8 of the status word are always 0, and bit k reflects only channel k.
- R12: A fresh channel whose `cfg_cnt` is 0 is dropped without issuing any unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_set | input | 8 | One-cycle request pulses, one bit per channel |
| cfg_src | input | 128 | Start source address per channel, 16 bits each |
| cfg_dst | input | 128 | Start destination address per channel, 16 bits each |
| cfg_cnt | input | 64 | Start unit count per channel, 8 bits each |
| xfer_done | input | 1 | The unit on the interface has completed |
| xfer_valid | output | 1 | A unit is being requested |
| xfer_ch | output | 3 | Channel owning the current unit |
| xfer_src | output | 16 | Source address of the current unit |
| xfer_dst | output | 16 | Destination address of the current unit |
| stat_pause | output | 32 | Suspended flags in bits 7:0, zeros above |

## Verification
The assertions check several rules on every cycle. The interface holds steady while a unit is outstanding. A suspended flag can rise only at a unit completion. A suspended channel always remains pending and is never the one on the interface. A grant always goes to the lowest pending channel. Other behaviour needs the bench's scenarios: whether a resumed channel picks up at the exact address it left, the order of service after nested suspensions, absorbed repeat requests, and zero-count starts. The bench sweeps every pair of channels through a preemption and compares the addresses it computes itself.

// File: rtl/dps_pkg.sv
// Shared types for the preemptive DMA scheduler.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dps_pkg;
    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_BUSY = 1'b1
    } sch_state_e;

    localparam int STAT_W = 32;
endpackage

// File: rtl/dps_lowest_pick.sv
// Fixed-priority picker: grants the lowest-numbered set bit of req.
// Assumes NCH >= 2; purely combinational.
module dps_lowest_pick #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req,
    output logic           gnt_valid,
    output logic [CHW-1:0] gnt_idx
);
    // Scan from the top down so the lowest set bit is written last.
    always_comb begin
        gnt_valid = |req;
        gnt_idx   = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) gnt_idx = CHW'(i);
        end
    end

    logic [NCH-1:0] below_gnt;
    // Mask of channels numbered below the grant, used only by the check.
    always_comb begin
        for (int i = 0; i < NCH; i++) below_gnt[i] = (i < int'(gnt_idx));
    end

    // R3
    lowest_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (req[gnt_idx] && ((req & below_gnt) == '0)));
endmodule

// File: rtl/dps_ctx_store.sv
// Per-channel resume context (remaining count, source, destination).
// One write port (save on suspend), one combinational read port.
module dps_ctx_store #(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int CW  = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_idx,
    input  logic [CW-1:0]  wr_cnt,
    input  logic [AW-1:0]  wr_src,
    input  logic [AW-1:0]  wr_dst,
    input  logic [CHW-1:0] rd_idx,
    output logic [CW-1:0]  rd_cnt,
    output logic [AW-1:0]  rd_src,
    output logic [AW-1:0]  rd_dst
);
    logic [CW-1:0] cnt_r [NCH];
    logic [AW-1:0] src_r [NCH];
    logic [AW-1:0] dst_r [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_slot
        // Capture a channel's context when it is the one being suspended.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_r[g] <= '0;
                src_r[g] <= '0;
                dst_r[g] <= '0;
            end else if (wr_en && (wr_idx == CHW'(g))) begin
                cnt_r[g] <= wr_cnt;
                src_r[g] <= wr_src;
                dst_r[g] <= wr_dst;
            end
        end
    end

    assign rd_cnt = cnt_r[rd_idx];
    assign rd_src = src_r[rd_idx];
    assign rd_dst = dst_r[rd_idx];
endmodule

// File: rtl/dps_flags.sv
// Pending-request and suspended flags for all channels.
// A clear of a pending flag wins over a same-cycle request for that channel.
module dps_flags #(
    parameter int NCH = 8,
    localparam int CHW = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] req_in,
    input  logic           pend_clr,
    input  logic [CHW-1:0] pend_clr_idx,
    input  logic           susp_set,
    input  logic           susp_clr,
    input  logic [CHW-1:0] susp_idx,
    output logic [NCH-1:0] pend_q,
    output logic [NCH-1:0] susp_q
);
    logic [NCH-1:0] pend_clr_vec;
    logic [NCH-1:0] susp_set_vec;
    logic [NCH-1:0] susp_clr_vec;

    // Decode the single-channel controls into bit vectors.
    always_comb begin
        pend_clr_vec = '0;
        susp_set_vec = '0;
        susp_clr_vec = '0;
        if (pend_clr) pend_clr_vec[pend_clr_idx] = 1'b1;
        if (susp_set) susp_set_vec[susp_idx] = 1'b1;
        if (susp_clr) susp_clr_vec[susp_idx] = 1'b1;
    end

    // Update both flag sets each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            susp_q <= '0;
        end else begin
            pend_q <= (pend_q | req_in) & ~pend_clr_vec;
            susp_q <= (susp_q | susp_set_vec) & ~susp_clr_vec;
        end
    end

    // R5
    susp_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_q & ~pend_q) == '0);

    // R5
    single_susp_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(susp_q & ~$past(susp_q)));
endmodule

// File: rtl/dma_preempt_sched.sv
// Preemptive eight-channel DMA scheduler. It picks the lowest pending or
// suspended channel, issues one data unit per xfer_done, and suspends the
// active channel at a unit boundary when a lower-numbered one is pending.
// Assumes xfer_done is only asserted while xfer_valid is high.
module dma_preempt_sched #(
    parameter int NCH  = 8,
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int STEP = 1,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    trig_set,
    input  logic [NCH*AW-1:0] cfg_src,
    input  logic [NCH*AW-1:0] cfg_dst,
    input  logic [NCH*CW-1:0] cfg_cnt,
    input  logic              xfer_done,
    output logic              xfer_valid,
    output logic [CHW-1:0]    xfer_ch,
    output logic [AW-1:0]     xfer_src,
    output logic [AW-1:0]     xfer_dst,
    output logic [31:0]       stat_pause
);
    import dps_pkg::*;

    sch_state_e     state_q;
    logic [CHW-1:0] act_q;
    logic [CW-1:0]  cnt_q;
    logic [AW-1:0]  src_q, dst_q;

    logic [NCH-1:0] pend, susp, higher;
    logic           gnt_v;
    logic [CHW-1:0] gnt_idx;
    logic [CW-1:0]  ctx_cnt, load_cnt;
    logic [AW-1:0]  ctx_src, ctx_dst, load_src, load_dst;
    logic           unit_done, last_unit, preempt, finish;
    logic           start, resume, drop;

    dps_flags #(.NCH(NCH)) u_flags (
        .clk(clk), .rst_n(rst_n), .req_in(trig_set),
        .pend_clr(finish | drop), .pend_clr_idx(finish ? act_q : gnt_idx),
        .susp_set(preempt), .susp_clr(resume),
        .susp_idx(preempt ? act_q : gnt_idx),
        .pend_q(pend), .susp_q(susp)
    );

    dps_lowest_pick #(.NCH(NCH)) u_pick (
        .clk(clk), .rst_n(rst_n), .req(pend | susp),
        .gnt_valid(gnt_v), .gnt_idx(gnt_idx)
    );

    dps_ctx_store #(.NCH(NCH), .AW(AW), .CW(CW)) u_ctx (
        .clk(clk), .rst_n(rst_n),
        .wr_en(preempt), .wr_idx(act_q),
        .wr_cnt(cnt_q - CW'(1)), .wr_src(src_q + AW'(STEP)),
        .wr_dst(dst_q + AW'(STEP)),
        .rd_idx(gnt_idx), .rd_cnt(ctx_cnt), .rd_src(ctx_src), .rd_dst(ctx_dst)
    );

    // Channels numbered below the active one that are waiting.
    always_comb begin
        for (int i = 0; i < NCH; i++) higher[i] = pend[i] && (i < int'(act_q));
    end

    // Start values: stored context for a suspended channel, else its config.
    always_comb begin
        if (susp[gnt_idx]) begin
            load_cnt = ctx_cnt;
            load_src = ctx_src;
            load_dst = ctx_dst;
        end else begin
            load_cnt = cfg_cnt[gnt_idx*CW +: CW];
            load_src = cfg_src[gnt_idx*AW +: AW];
            load_dst = cfg_dst[gnt_idx*AW +: AW];
        end
    end

    assign unit_done = (state_q == SCH_BUSY) && xfer_done;
    assign last_unit = (cnt_q == CW'(1));
    assign finish    = unit_done && last_unit;
    assign preempt   = unit_done && !last_unit && (|higher);
    assign start     = (state_q == SCH_IDLE) && gnt_v;
    assign resume    = start && susp[gnt_idx];
    assign drop      = start && !susp[gnt_idx] && (load_cnt == '0);

    // Sequencer: load on grant, advance per unit, leave on finish or suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCH_IDLE;
            act_q   <= '0;
            cnt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
        end else if (start && !drop) begin
            state_q <= SCH_BUSY;
            act_q   <= gnt_idx;
            cnt_q   <= load_cnt;
            src_q   <= load_src;
            dst_q   <= load_dst;
        end else if (unit_done) begin
            cnt_q <= cnt_q - CW'(1);
            src_q <= src_q + AW'(STEP);
            dst_q <= dst_q + AW'(STEP);
            if (finish || preempt) state_q <= SCH_IDLE;
        end
    end

    assign xfer_valid = (state_q == SCH_BUSY);
    assign xfer_ch    = act_q;
    assign xfer_src   = src_q;
    assign xfer_dst   = dst_q;
    assign stat_pause = {{(32-NCH){1'b0}}, susp};

    // R4
    hold_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !xfer_done) |=>
            (xfer_valid && $stable(xfer_ch) && $stable(xfer_src) && $stable(xfer_dst)));

    // R5
    susp_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_pause[NCH-1:0] & ~$past(stat_pause[NCH-1:0])) != '0) |->
            $past(xfer_valid && xfer_done));

    // R7
    active_not_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !stat_pause[xfer_ch]);

    // R2
    live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (cnt_q != '0));
endmodule

// File: tb/dma_preempt_sched_test.sv
module dma_preempt_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int CW  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH-1:0]    trig_set = '0;
    logic [NCH*AW-1:0] cfg_src = '0;
    logic [NCH*AW-1:0] cfg_dst = '0;
    logic [NCH*CW-1:0] cfg_cnt = '0;
    logic              xfer_done = 1'b0;
    logic              xfer_valid;
    logic [2:0]        xfer_ch;
    logic [AW-1:0]     xfer_src, xfer_dst;
    logic [31:0]       stat_pause;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    dma_preempt_sched uut (
        .clk(clk), .rst_n(rst_n), .trig_set(trig_set),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
        .xfer_done(xfer_done), .xfer_valid(xfer_valid), .xfer_ch(xfer_ch),
        .xfer_src(xfer_src), .xfer_dst(xfer_dst), .stat_pause(stat_pause)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int ch, input logic [AW-1:0] s,
                           input logic [AW-1:0] d, input logic [CW-1:0] n);
        cfg_src[ch*AW +: AW] = s;
        cfg_dst[ch*AW +: AW] = d;
        cfg_cnt[ch*CW +: CW] = n;
    endtask

    task automatic pulse(input logic [NCH-1:0] m);
        trig_set = m;
        @(negedge clk);
        trig_set = '0;
        @(negedge clk);
    endtask

    // Wait for a unit, compare it with the expected one, then complete it.
    task automatic unit(input string req, input int ch,
                        input logic [AW-1:0] s, input logic [AW-1:0] d);
        for (int w = 0; w < 20 && !xfer_valid; w++) @(negedge clk);
        check({req, " valid"}, 32'(xfer_valid), 32'd1);
        check({req, " ch"}, 32'(xfer_ch), 32'(ch));
        check({req, " src"}, 32'(xfer_src), 32'(s));
        check({req, " dst"}, 32'(xfer_dst), 32'(d));
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    function automatic logic [AW-1:0] sa(input int ch);
        return AW'(ch << 8);
    endfunction
    function automatic logic [AW-1:0] da(input int ch);
        return AW'(16'h8000 | (ch << 8));
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 status", stat_pause, 32'd0);
        check("R1 valid", 32'(xfer_valid), 32'd0);

        // R2 plain run on channel 5
        set_cfg(5, 16'h0100, 16'h0200, 8'd4);
        pulse(8'h20);
        for (int k = 0; k < 4; k++) unit("R2 run", 5, 16'h0100 + AW'(k), 16'h0200 + AW'(k));
        check("R2 idle after count", 32'(xfer_valid), 32'd0);
        check("R11 status after run", stat_pause, 32'd0);

        // R3 simultaneous requests from channels 3 and 5
        set_cfg(3, 16'h0300, 16'h0400, 8'd2);
        set_cfg(5, 16'h0500, 16'h0600, 8'd2);
        pulse(8'h28);
        unit("R3 low first", 3, 16'h0300, 16'h0400);
        unit("R3 low first", 3, 16'h0301, 16'h0401);
        unit("R3 then high", 5, 16'h0500, 16'h0600);
        unit("R3 then high", 5, 16'h0501, 16'h0601);

        // R10 repeat request for the active channel
        set_cfg(5, 16'h0700, 16'h0800, 8'd3);
        pulse(8'h20);
        unit("R10 run", 5, 16'h0700, 16'h0800);
        pulse(8'h20);
        check("R10 no suspend", stat_pause, 32'd0);
        unit("R10 run", 5, 16'h0701, 16'h0801);
        unit("R10 run", 5, 16'h0702, 16'h0802);
        repeat (4) @(negedge clk);
        check("R10 no second run", 32'(xfer_valid), 32'd0);

        // R12 zero count dropped
        set_cfg(0, 16'h0900, 16'h0A00, 8'd0);
        pulse(8'h01);
        repeat (3) @(negedge clk);
        check("R12 no unit", 32'(xfer_valid), 32'd0);
        set_cfg(0, 16'h0900, 16'h0A00, 8'd1);
        pulse(8'h01);
        unit("R12 later run", 0, 16'h0900, 16'h0A00);

        // Sweep of every preempting pair
        for (int hi = 0; hi < NCH - 1; hi++) begin
            for (int lo = hi + 1; lo < NCH; lo++) begin
                set_cfg(lo, sa(lo), da(lo), 8'd4);
                set_cfg(hi, sa(hi) | 16'h0080, da(hi) | 16'h0080, 8'd2);
                pulse(NCH'(1) << lo);
                unit("R2 sweep", lo, sa(lo), da(lo));
                pulse(NCH'(1) << hi);
                // R4 the outstanding unit is not cut short
                check("R4 hold ch", 32'(xfer_ch), 32'(lo));
                check("R4 hold src", 32'(xfer_src), 32'(sa(lo) + 1));
                unit("R4 boundary", lo, sa(lo) + 1, da(lo) + 1);
                check("R5 suspend flag", stat_pause, 32'(1) << lo);
                check("R5 gap", 32'(xfer_valid), 32'd0);
                unit("R6 preemptor", hi, sa(hi) | 16'h0080, da(hi) | 16'h0080);
                // R7 new start values and a repeat request must not matter
                set_cfg(lo, 16'hFF00, 16'hEE00, 8'd9);
                pulse(NCH'(1) << lo);
                unit("R6 preemptor", hi, (sa(hi) | 16'h0080) + 1, (da(hi) | 16'h0080) + 1);
                unit("R7 resume", lo, sa(lo) + 2, da(lo) + 2);
                check("R7 flag cleared", stat_pause, 32'd0);
                unit("R7 resume", lo, sa(lo) + 3, da(lo) + 3);
                @(negedge clk);
                check("R7 done", 32'(xfer_valid), 32'd0);
            end
        end

        // R9 nested suspension 7 <- 4 <- 1, then R8 ordered resume
        set_cfg(7, sa(7), da(7), 8'd3);
        set_cfg(4, sa(4), da(4), 8'd3);
        set_cfg(1, sa(1), da(1), 8'd2);
        pulse(8'h80);
        unit("R9 base", 7, sa(7), da(7));
        pulse(8'h10);
        unit("R9 base", 7, sa(7) + 1, da(7) + 1);
        unit("R9 middle", 4, sa(4), da(4));
        pulse(8'h02);
        unit("R9 middle", 4, sa(4) + 1, da(4) + 1);
        check("R9 two flags", stat_pause, 32'h0000_0090);
        unit("R9 top", 1, sa(1), da(1));
        unit("R9 top", 1, sa(1) + 1, da(1) + 1);
        unit("R8 lower number first", 4, sa(4) + 2, da(4) + 2);
        check("R8 one flag left", stat_pause, 32'h0000_0080);
        unit("R8 last", 7, sa(7) + 2, da(7) + 2);
        @(negedge clk);
        check("R11 final status", stat_pause, 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule